// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Logic

This block is a memory-mapped general-purpose I/O port of up to 32 pins. A simple register bus (byte address, write strobe, write data, combinational read data) gives software control of each pin's output driver and output level, and lets it read the synchronized pin levels. Outputs change only through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed.

Every pin also has its own interrupt logic. Four per-pin controls shape it: an enable, a separate mask, a type (edge or level) and a polarity. Edge events are latched into a pending bit that stays until software clears it. Level conditions are shown live. One registered, active-high line reports whether any pin is pending, enabled and unmasked. The hardware detects only one edge direction at a time. Software can watch both edges by rewriting a pin's polarity to the opposite of its present level after each event. The pending logic is built so that such a rewrite neither loses nor fakes an event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all low and `irq_o` is low.
- R2: Registers sit at byte addresses: direction 0x00, input level 0x04, output-set 0x0C, output-clear 0x10, interrupt enable 0x14, interrupt type 0x18, interrupt polarity 0x1C, interrupt pending 0x20, interrupt mask 0x24. Direction, enable, type, polarity and mask read back what was written. Data bit i belongs to pin i. Bits at or above NUM_PINS read 0, and any other address reads 0. Direction bits drive `pin_oe` directly.
- R3: Pin inputs pass through two flip-flops. A level present on `pin_in` before clock edge k reads back at 0x04 from edge k+1 on, and not after edge k alone.
- R4: Writing 1 to a bit at 0x0C drives that bit of `pin_out` high. Writing 0 leaves it unchanged. Reads at 0x0C and at 0x10 both return the current output levels.
- R5: Writing 1 to a bit at 0x10 drives that bit of `pin_out` low. Writing 0 leaves it unchanged.
- R6: With type bit 0 (edge), polarity 1 latches the pending bit on a rising synchronized input, and polarity 0 latches it on a falling one. The other edge direction does not latch.
- R7: An edge-mode pending bit stays set until a 1 is written to that bit at 0x20. Writing 0 there has no effect.
- R8: With type bit 1 (level), the pending bit reads 1 exactly while the pin is enabled and its synchronized level equals its polarity bit. Writes to 0x20 do not change it.
- R9: A pin whose enable bit is 0 never latches an edge pending bit, and it reads 0 in level mode.
- R10: Rewriting a pin's polarity while its input is steady neither sets nor clears its pending bit. After the pending bit is cleared, the next edge in the new direction latches again.
- R11: `irq_o` is a register that holds the OR over all pins of pending AND enable AND mask. It follows that term one clock edge later. A pin with mask 0 keeps its pending bit readable but cannot raise `irq_o`.
- R12: For an edge that appears on `pin_in` before clock edge k, the pending bit is still 0 after edge k+1. It reads 1 after edge k+2, and `irq_o` rises after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output-driver enables |
| irq_o | output | 1 | Combined interrupt, registered, active high |

## Verification
The bench builds the port with NUM_PINS = 4. At that width every one of the 16 input and output patterns can be swept: all set and clear pattern pairs, every input pattern under both level polarities, and every pin under both edge directions. The exact edge-to-pending and pending-to-interrupt latencies are checked on every pin. The both-edge emulation sequence, the mask gate and the disabled-pin case are run as directed sequences on the same small port.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned GPIO_ADDR_W = 8;
    localparam int unsigned GPIO_DATA_W = 32;

    // Byte offsets of the register window
    localparam logic [GPIO_ADDR_W-1:0] OFS_DIR   = 8'h00;
    localparam logic [GPIO_ADDR_W-1:0] OFS_LEVEL = 8'h04;
    localparam logic [GPIO_ADDR_W-1:0] OFS_SET   = 8'h0C;
    localparam logic [GPIO_ADDR_W-1:0] OFS_CLR   = 8'h10;
    localparam logic [GPIO_ADDR_W-1:0] OFS_IEN   = 8'h14;
    localparam logic [GPIO_ADDR_W-1:0] OFS_ITYPE = 8'h18;
    localparam logic [GPIO_ADDR_W-1:0] OFS_IPOL  = 8'h1C;
    localparam logic [GPIO_ADDR_W-1:0] OFS_IPEND = 8'h20;
    localparam logic [GPIO_ADDR_W-1:0] OFS_IMASK = 8'h24;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_LEVEL,
        SEL_SET,
        SEL_CLR,
        SEL_IEN,
        SEL_ITYPE,
        SEL_IPOL,
        SEL_IPEND,
        SEL_IMASK
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [GPIO_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_DIR:   s = SEL_DIR;
            OFS_LEVEL: s = SEL_LEVEL;
            OFS_SET:   s = SEL_SET;
            OFS_CLR:   s = SEL_CLR;
            OFS_IEN:   s = SEL_IEN;
            OFS_ITYPE: s = SEL_ITYPE;
            OFS_IPOL:  s = SEL_IPOL;
            OFS_IPEND: s = SEL_IPEND;
            OFS_IMASK: s = SEL_IMASK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] st1;
        logic [WIDTH-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = async_i;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.st2;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,   // synchronized pin level
    input  logic en_i,
    input  logic lvl_mode_i, // 1: level, 0: edge
    input  logic pol_i,     // 1: high / rising, 0: low / falling
    input  logic clr_i,     // write-one-to-clear strobe
    output logic pend_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  edge_hit;
    logic  lvl_match;

    always_comb begin
        cell_d      = cell_q;
        cell_d.prev = level_i;
        lvl_match   = (level_i == pol_i);
        if (pol_i) begin
            edge_hit = level_i & ~cell_q.prev;
        end else begin
            edge_hit = ~level_i & cell_q.prev;
        end
        if (lvl_mode_i) begin
            cell_d.pend = en_i & lvl_match;
        end else begin
            // a new event wins over a clear in the same cycle
            cell_d.pend = (cell_q.pend & ~clr_i) | (en_i & edge_hit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign pend_o = cell_q.pend;

    assert_disabled_no_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !lvl_mode_i && !pend_o) |=> !pend_o);

    assert_clear_edge_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !lvl_mode_i && !(en_i && edge_hit)) |=> !pend_o);

    assert_level_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode_i && en_i && (level_i == pol_i)) |=> pend_o);

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [GPIO_DATA_W-1:0] bus_wdata,
    output logic [GPIO_DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0]    level_i,
    input  logic [NUM_PINS-1:0]    pend_i,
    output logic [NUM_PINS-1:0]    dir_o,
    output logic [NUM_PINS-1:0]    drv_o,
    output logic [NUM_PINS-1:0]    ien_o,
    output logic [NUM_PINS-1:0]    itype_o,
    output logic [NUM_PINS-1:0]    ipol_o,
    output logic [NUM_PINS-1:0]    imask_o,
    output logic [NUM_PINS-1:0]    pend_clr_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] drv;
        logic [NUM_PINS-1:0] ien;
        logic [NUM_PINS-1:0] itype;
        logic [NUM_PINS-1:0] ipol;
        logic [NUM_PINS-1:0] imask;
    } regs_t;

    regs_t               regs_d, regs_q;
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] rbits;

    assign sel   = decode_addr(bus_addr);
    assign wbits = bus_wdata[NUM_PINS-1:0];

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (sel)
                SEL_DIR:   regs_d.dir   = wbits;
                SEL_SET:   regs_d.drv   = regs_q.drv | wbits;
                SEL_CLR:   regs_d.drv   = regs_q.drv & ~wbits;
                SEL_IEN:   regs_d.ien   = wbits;
                SEL_ITYPE: regs_d.itype = wbits;
                SEL_IPOL:  regs_d.ipol  = wbits;
                SEL_IMASK: regs_d.imask = wbits;
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:   rbits = regs_q.dir;
            SEL_LEVEL: rbits = level_i;
            SEL_SET:   rbits = regs_q.drv;
            SEL_CLR:   rbits = regs_q.drv;
            SEL_IEN:   rbits = regs_q.ien;
            SEL_ITYPE: rbits = regs_q.itype;
            SEL_IPOL:  rbits = regs_q.ipol;
            SEL_IPEND: rbits = pend_i;
            SEL_IMASK: rbits = regs_q.imask;
            default:   rbits = '0;
        endcase
        bus_rdata                = '0;
        bus_rdata[NUM_PINS-1:0]  = rbits;
    end

    assign pend_clr_o = (bus_we && (sel == SEL_IPEND)) ? wbits : '0;
    assign dir_o      = regs_q.dir;
    assign drv_o      = regs_q.drv;
    assign ien_o      = regs_q.ien;
    assign itype_o    = regs_q.itype;
    assign ipol_o     = regs_q.ipol;
    assign imask_o    = regs_q.imask;

    assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_SET) |=>
            ((drv_o & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    assert_clear_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_CLR) |=> ((drv_o & $past(bus_wdata[NUM_PINS-1:0])) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [GPIO_DATA_W-1:0] bus_wdata,
    output logic [GPIO_DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0]    pin_in,
    output logic [NUM_PINS-1:0]    pin_out,
    output logic [NUM_PINS-1:0]    pin_oe,
    output logic                   irq_o
);

    logic [NUM_PINS-1:0] level_s;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] ien, itype, ipol, imask, pend_clr;

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    gpio_sync2 #(.WIDTH(NUM_PINS)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (level_s)
    );

    gpio_reg_file #(.NUM_PINS(NUM_PINS)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .level_i    (level_s),
        .pend_i     (pend),
        .dir_o      (pin_oe),
        .drv_o      (pin_out),
        .ien_o      (ien),
        .itype_o    (itype),
        .ipol_o     (ipol),
        .imask_o    (imask),
        .pend_clr_o (pend_clr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
        gpio_irq_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (level_s[g]),
            .en_i       (ien[g]),
            .lvl_mode_i (itype[g]),
            .pol_i      (ipol[g]),
            .clr_i      (pend_clr[g]),
            .pend_o     (pend[g])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = |(pend & ien & imask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq_o = top_q.irq;

    assert_masked_blocks_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == '0) |=> !irq_o);

    assert_disabled_blocks_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |=> !irq_o);

endmodule

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;

    localparam int N = 4;
    localparam logic [3:0] ALL = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    gpio_irq_port #(.NUM_PINS(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_o     (irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 8'h00;
        bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_v;
        logic [3:0] act_lvl;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 oe", {28'd0, pin_oe}, 0);
        chk("R1 out", {28'd0, pin_out}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk_rd("R1 dir", 8'h00, 0);
        chk_rd("R1 set", 8'h0C, 0);
        chk_rd("R1 ien", 8'h14, 0);
        chk_rd("R1 type", 8'h18, 0);
        chk_rd("R1 pol", 8'h1C, 0);
        chk_rd("R1 pend", 8'h20, 0);
        chk_rd("R1 mask", 8'h24, 0);

        // R2 readback, width clipping, unmapped addresses
        for (int v = 0; v < 16; v++) begin
            bus_wr(8'h00, 32'hFFFF_FFF0 | v);
            chk_rd("R2 dir", 8'h00, v);
            chk("R2 pin_oe", {28'd0, pin_oe}, v);
        end
        bus_wr(8'h00, 0);
        bus_wr(8'h14, 32'hFFFF_FFFF); chk_rd("R2 ien", 8'h14, 32'hF);
        bus_wr(8'h18, 32'hFFFF_FFFA); chk_rd("R2 type", 8'h18, 32'hA);
        bus_wr(8'h1C, 32'hFFFF_FFF5); chk_rd("R2 pol", 8'h1C, 32'h5);
        bus_wr(8'h24, 32'hFFFF_FFF3); chk_rd("R2 mask", 8'h24, 32'h3);
        bus_wr(8'h14, 0); bus_wr(8'h18, 0); bus_wr(8'h1C, 0); bus_wr(8'h24, 0);
        chk_rd("R2 unmapped 08", 8'h08, 0);
        chk_rd("R2 unmapped 28", 8'h28, 0);

        // R3 two-stage synchronizer latency
        for (int v = 1; v < 16; v++) begin
            logic [3:0] prev_v;
            prev_v = pin_in;
            pin_in = v[3:0];
            tick(1);
            chk_rd("R3 one edge", 8'h04, {28'd0, prev_v});
            tick(1);
            chk_rd("R3 two edges", 8'h04, v);
        end
        pin_in = 0;
        tick(3);

        // R4 / R5 set and clear sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bus_wr(8'h10, ALL);
                bus_wr(8'h0C, a);
                chk("R4 set", {28'd0, pin_out}, a);
                chk_rd("R4 read set", 8'h0C, a);
                bus_wr(8'h10, b);
                exp_v = a[3:0] & ~b[3:0];
                chk("R5 clear", {28'd0, pin_out}, {28'd0, exp_v});
                chk_rd("R4 read clr", 8'h10, {28'd0, exp_v});
            end
        end
        bus_wr(8'h10, ALL);

        // R6 / R7 / R12 edge mode per pin and direction
        for (int p = 0; p < N; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [3:0] idle;
                idle = (pol != 0) ? 4'h0 : ALL;
                bus_wr(8'h18, 0);
                bus_wr(8'h1C, (pol != 0) ? ALL : 0);
                bus_wr(8'h14, ALL);
                bus_wr(8'h24, ALL);
                pin_in = idle;
                tick(4);
                bus_wr(8'h20, ALL);
                chk_rd("R7 cleared", 8'h20, 0);
                tick(1);
                chk("R11 idle irq", {31'd0, irq_o}, 0);
                pin_in = idle ^ (4'h1 << p);
                tick(2);
                chk_rd("R12 not yet", 8'h20, 0);
                tick(1);
                chk_rd("R6 edge latched", 8'h20, 1 << p);
                chk("R12 irq not yet", {31'd0, irq_o}, 0);
                tick(1);
                chk("R12 irq up", {31'd0, irq_o}, 1);
                bus_wr(8'h20, 0);
                chk_rd("R7 write zero", 8'h20, 1 << p);
                bus_wr(8'h20, 1 << p);
                chk_rd("R7 write one", 8'h20, 0);
                tick(1);
                chk("R11 irq drops", {31'd0, irq_o}, 0);
                pin_in = idle;
                tick(4);
                chk_rd("R6 opposite edge", 8'h20, 0);
            end
        end

        // R8 level mode, all patterns, both polarities
        bus_wr(8'h18, ALL);
        for (int pol = 0; pol < 2; pol++) begin
            bus_wr(8'h1C, (pol != 0) ? ALL : 0);
            for (int v = 0; v < 16; v++) begin
                pin_in = v[3:0];
                tick(3);
                exp_v = (pol != 0) ? v[3:0] : ~v[3:0];
                chk_rd("R8 level", 8'h20, {28'd0, exp_v});
                bus_wr(8'h20, ALL);
                chk_rd("R8 clear ignored", 8'h20, {28'd0, exp_v});
                tick(1);
                chk("R11 level irq", {31'd0, irq_o}, {31'd0, exp_v != 0});
            end
        end

        // R9 disabled pins
        bus_wr(8'h14, 0);
        bus_wr(8'h1C, ALL);
        pin_in = ALL;
        tick(4);
        chk_rd("R9 level disabled", 8'h20, 0);
        bus_wr(8'h18, 0);
        pin_in = 0;
        tick(4);
        bus_wr(8'h20, ALL);
        pin_in = ALL;
        tick(4);
        chk_rd("R9 edge disabled", 8'h20, 0);
        chk("R9 irq", {31'd0, irq_o}, 0);

        // R11 mask gate
        bus_wr(8'h24, 0);
        bus_wr(8'h14, ALL);
        pin_in = 0;
        tick(4);
        bus_wr(8'h20, ALL);
        pin_in = ALL;
        tick(4);
        chk_rd("R11 pending while masked", 8'h20, 32'hF);
        chk("R11 masked irq", {31'd0, irq_o}, 0);
        bus_wr(8'h24, 32'h4);
        tick(1);
        chk("R11 unmasked irq", {31'd0, irq_o}, 1);
        bus_wr(8'h20, 32'h4);
        tick(1);
        chk("R11 other pins masked", {31'd0, irq_o}, 0);
        bus_wr(8'h24, ALL);
        bus_wr(8'h20, ALL);

        // R10 both-edge emulation on pin 1
        bus_wr(8'h1C, ALL);
        pin_in = 4'h0;
        tick(4);
        bus_wr(8'h20, ALL);
        pin_in = 4'h2;
        tick(4);
        chk_rd("R10 rise latched", 8'h20, 32'h2);
        bus_wr(8'h1C, ALL & ~4'h2);
        tick(4);
        chk_rd("R10 polarity flip keeps pending", 8'h20, 32'h2);
        bus_wr(8'h20, 32'h2);
        tick(4);
        chk_rd("R10 no event from flip", 8'h20, 0);
        pin_in = 4'h0;
        tick(4);
        chk_rd("R10 fall latched", 8'h20, 32'h2);
        bus_wr(8'h1C, ALL);
        bus_wr(8'h20, 32'h2);
        tick(4);
        chk_rd("R10 re-armed quiet", 8'h20, 0);
        pin_in = 4'h2;
        tick(4);
        act_lvl = bus_rdata[3:0];
        chk_rd("R10 rise again", 8'h20, 32'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule